// File: doc/BRIEF.md
# I2C Two-Stage Baud Generator

This block produces the timing strobes for an I2C master from the core clock. A 7-bit baud setting holds two fields. A 4-bit linear field M sets a divide-by-(M+1) stage. A 3-bit exponent field N sets a power-of-two prescaler that runs ahead of the linear stage. A fixed divide-by-ten stage comes after the linear stage. The block has two outputs. `phase_tick` gives ten timing phases per SCL period. `scl_tick` marks the end of each full SCL period. In the default mode the SCL frequency is fclk / (10·(M+1)·2^(N+1)). A build parameter selects a second mode that drops the extra factor of two from the prescaler.

The bus state machine writes the setting through a one-cycle write strobe and can read it back. A soft-reset input returns the setting to its power-on value. Both a write and a soft reset restart the whole divider chain from zero, so the first tick after a change always comes after one full period at the new rate.

Top module: `i2c_baud_gen`

## Requirements
- R1: While `rst_n` is low and after it rises, `baud_q` reads 0x44 (M=8, N=4). No tick is issued during reset.
- R2: M sits in bits 6:3 and N sits in bits 2:0 of the setting. In the default mode `phase_tick` is a one-cycle pulse every (M+1)·2^(N+1) clock cycles.
- R3: With `EXP_MODE` set to `EXP_N`, the `phase_tick` spacing is (M+1)·2^N clock cycles.
- R4: `scl_tick` pulses in the same cycle as every tenth `phase_tick`, counted from the last restart.
- R5: A write with `baud_we` loads `baud_wdata` at that clock edge and restarts every counter. With P the new period, the first `phase_tick` falls P cycles after that edge and the first `scl_tick` falls 10·P cycles after it. No shorter interval appears.
- R6: `soft_rst` restores 0x44 and restarts every counter. If it is high in the same cycle as `baud_we`, the write is ignored.
- R7: With the setting 0x00 in the default mode, `phase_tick` pulses every 2 clock cycles.
- R8: `scl_tick` is never high in a cycle where `phase_tick` is low.
- R9: With neither `baud_we` nor `soft_rst` high, `baud_q` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restore of the setting to its reset value, with a counter restart |
| baud_we | input | 1 | Write strobe for the baud setting |
| baud_wdata | input | 7 | New setting: M in bits 6:3, N in bits 2:0 |
| baud_q | output | 7 | Current setting |
| phase_tick | output | 1 | One-cycle pulse, ten per SCL period |
| scl_tick | output | 1 | One-cycle pulse at the end of each SCL period |

## Verification
Some writes arrive in the middle of a period. After each one the bench measures where the first tick falls, which catches a design that keeps the old count and emits a runt tick. The bench runs 0x00 and 0x7F in both prescaler modes. An off-by-one in the power-of-two mask would give a period of 1 or 4 at the low end, and a too-narrow counter would wrap early at the high end. The asymmetric setting 0x0B would expose swapped field positions. A soft reset raised together with a write would show a wrong priority as a period of 32 instead of 288.

// File: rtl/i2c_baud_gen_pkg.sv
`timescale 1ns/1ps
package i2c_baud_gen_pkg;
   // Prescaler exponent variant: 2^(N+1) or 2^N core clocks per prescaler step
   typedef enum logic {
      EXP_N_PLUS_1 = 1'b0,
      EXP_N        = 1'b1
   } exp_mode_e;

   function automatic int exp_shift(exp_mode_e mode);
      return (mode == EXP_N_PLUS_1) ? 1 : 0;
   endfunction
endpackage

// File: rtl/i2c_bg_baud_reg.sv
`timescale 1ns/1ps
module i2c_bg_baud_reg #(
   parameter int BW = 7,
   parameter logic [BW-1:0] RESET_VAL = 7'h44
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          we,
   input  logic [BW-1:0] wdata,
   output logic [BW-1:0] q,
   output logic          restart
);
   // Soft reset wins over a write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= RESET_VAL;
      else if (soft_rst) q <= RESET_VAL;
      else if (we)       q <= wdata;
   end

   assign restart = soft_rst | we;
endmodule

// File: rtl/i2c_bg_exp_prescaler.sv
`timescale 1ns/1ps
module i2c_bg_exp_prescaler
   import i2c_baud_gen_pkg::*;
#(
   parameter int        N_W      = 3,
   parameter exp_mode_e EXP_MODE = EXP_N_PLUS_1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           restart,
   input  logic [N_W-1:0] n_fld,
   output logic           stb
);
   localparam int SHIFT  = exp_shift(EXP_MODE);
   localparam int CW_RAW = (1 << N_W) - 1 + SHIFT;
   localparam int CW     = (CW_RAW < 1) ? 1 : CW_RAW;

   logic [N_W:0]  expo;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   generate
      if (SHIFT == 1) begin : g_n_plus_1
         assign expo = {1'b0, n_fld} + {{N_W{1'b0}}, 1'b1};
      end else begin : g_n
         assign expo = {1'b0, n_fld};
      end
   endgenerate

   // Terminal count: low 'expo' bits set
   assign lim = ~({CW{1'b1}} << expo);
   assign stb = (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (stb)     cnt <= '0;
      else              cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/i2c_bg_stage_counter.sv
`timescale 1ns/1ps
module i2c_bg_stage_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         en,
   input  logic [W-1:0] last,
   output logic         tick
);
   logic [W-1:0] cnt;

   assign tick = en && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (tick)    cnt <= '0;
      else if (en)      cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/i2c_baud_gen.sv
`timescale 1ns/1ps
module i2c_baud_gen
   import i2c_baud_gen_pkg::*;
#(
   parameter int              M_W       = 4,
   parameter int              N_W       = 3,
   parameter int              PHASES    = 10,
   parameter exp_mode_e       EXP_MODE  = EXP_N_PLUS_1,
   parameter logic [M_W+N_W-1:0] RESET_BAUD = 7'h44
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               baud_we,
   input  logic [M_W+N_W-1:0] baud_wdata,
   output logic [M_W+N_W-1:0] baud_q,
   output logic               phase_tick,
   output logic               scl_tick
);
   localparam int BW  = M_W + N_W;
   localparam int PCW = $clog2(PHASES);

   generate
      if (M_W < 1 || N_W < 1 || N_W > 5) begin : g_bad_width
         $error("i2c_baud_gen: field widths out of range");
      end
      if (PHASES < 2) begin : g_bad_phases
         $error("i2c_baud_gen: PHASES must be at least 2");
      end
   endgenerate

   logic           restart;
   logic           pre_stb;
   logic [M_W-1:0] m_fld;
   logic [N_W-1:0] n_fld;

   i2c_bg_baud_reg #(.BW(BW), .RESET_VAL(RESET_BAUD)) u_reg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .we(baud_we),
      .wdata(baud_wdata), .q(baud_q), .restart(restart)
   );

   assign m_fld = baud_q[BW-1:N_W];
   assign n_fld = baud_q[N_W-1:0];

   i2c_bg_exp_prescaler #(.N_W(N_W), .EXP_MODE(EXP_MODE)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(restart), .n_fld(n_fld), .stb(pre_stb)
   );

   i2c_bg_stage_counter #(.W(M_W)) u_lin (
      .clk(clk), .rst_n(rst_n), .restart(restart), .en(pre_stb),
      .last(m_fld), .tick(phase_tick)
   );

   i2c_bg_stage_counter #(.W(PCW)) u_dec (
      .clk(clk), .rst_n(rst_n), .restart(restart), .en(phase_tick),
      .last(PCW'(PHASES - 1)), .tick(scl_tick)
   );
endmodule

// File: rtl/i2c_baud_gen_chk.sv
`timescale 1ns/1ps
module i2c_baud_gen_chk
   import i2c_baud_gen_pkg::*;
#(
   parameter int              M_W       = 4,
   parameter int              N_W       = 3,
   parameter int              PHASES    = 10,
   parameter exp_mode_e       EXP_MODE  = EXP_N_PLUS_1,
   parameter logic [M_W+N_W-1:0] RESET_BAUD = 7'h44
) (
   input logic               clk,
   input logic               rst_n,
   input logic               soft_rst,
   input logic               baud_we,
   input logic [M_W+N_W-1:0] baud_wdata,
   input logic [M_W+N_W-1:0] baud_q,
   input logic               phase_tick,
   input logic               scl_tick
);
   localparam int BW    = M_W + N_W;
   localparam int GW    = M_W + (1 << N_W) + 2;
   localparam int PCW   = $clog2(PHASES);
   localparam int SHIFT = exp_shift(EXP_MODE);

   logic [GW-1:0]  period, gap;
   logic [PCW-1:0] pcnt;
   logic           restart;

   assign restart = baud_we | soft_rst;
   assign period  = (GW'(baud_q[BW-1:N_W]) + GW'(1)) << (GW'(baud_q[N_W-1:0]) + GW'(SHIFT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         pcnt <= '0;
      end else if (restart) begin
         gap  <= '0;
         pcnt <= '0;
      end else begin
         gap <= phase_tick ? '0 : gap + GW'(1);
         if (phase_tick) pcnt <= (pcnt == PCW'(PHASES - 1)) ? '0 : pcnt + PCW'(1);
      end
   end

   // Spacing since the last tick or restart (also covers R5: no runt)
   assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phase_tick |-> (gap == period - GW'(1)));
   assert_scl_tenth_R4: assert property (@(posedge clk) disable iff (!rst_n)
      scl_tick |-> (pcnt == PCW'(PHASES - 1)));
   assert_tenth_scl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_tick && pcnt == PCW'(PHASES - 1)) |-> scl_tick);
   assert_scl_in_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_tick |-> phase_tick);
   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_we && !soft_rst) |=> (baud_q == $past(baud_wdata)));
   assert_soft_R6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (baud_q == RESET_BAUD));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!baud_we && !soft_rst) |=> $stable(baud_q));
endmodule

bind i2c_baud_gen i2c_baud_gen_chk #(
   .M_W(M_W), .N_W(N_W), .PHASES(PHASES), .EXP_MODE(EXP_MODE), .RESET_BAUD(RESET_BAUD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_we(baud_we),
   .baud_wdata(baud_wdata), .baud_q(baud_q), .phase_tick(phase_tick), .scl_tick(scl_tick)
);

// File: tb/sim_i2c_baud_gen.sv
`timescale 1ns/1ps
module sim_i2c_baud_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       baud_we = 1'b0;
   logic [6:0] baud_wdata = '0;
   logic [6:0] q0, q1;
   logic       pt0, pt1, st0, st1;
   int         nchk = 0;
   int         nerr = 0;

   always #5 clk = ~clk;

   i2c_baud_gen u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_we(baud_we),
      .baud_wdata(baud_wdata), .baud_q(q0), .phase_tick(pt0), .scl_tick(st0)
   );

   i2c_baud_gen #(.EXP_MODE(i2c_baud_gen_pkg::EXP_N)) u1 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_we(baud_we),
      .baud_wdata(baud_wdata), .baud_q(q1), .phase_tick(pt1), .scl_tick(st1)
   );

   function automatic int per(logic [6:0] v, int sh);
      return (int'(v[6:3]) + 1) << (int'(v[2:0]) + sh);
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Called right after the restart edge; samples cycle k = 1 .. 10*max period
   task automatic window(int p0, int p1, string req0);
      int bad0 = 0, bad1 = 0, bads = 0, badr8 = 0;
      int lim = 10 * ((p0 > p1) ? p0 : p1);
      for (int k = 1; k <= lim; k++) begin
         if (bad0 == 0 && pt0 !== ((k % p0) == 0)) bad0 = k;
         if (bad1 == 0 && pt1 !== ((k % p1) == 0)) bad1 = k;
         if (bads == 0 && (st0 !== ((k % (10 * p0)) == 0) ||
                           st1 !== ((k % (10 * p1)) == 0))) bads = k;
         if (badr8 == 0 && ((st0 && !pt0) || (st1 && !pt1))) badr8 = k;
         @(negedge clk);
      end
      check(bad0 == 0, req0, "phase_tick first wrong cycle", bad0, 0);
      check(bad1 == 0, "R3", "alt-mode phase_tick first wrong cycle", bad1, 0);
      check(bads == 0, "R4", "scl_tick first wrong cycle", bads, 0);
      check(badr8 == 0, "R8", "scl_tick without phase_tick at cycle", badr8, 0);
   endtask

   task automatic pulse(bit s, bit w, logic [6:0] v);
      @(negedge clk);
      soft_rst = s; baud_we = w; baud_wdata = v;
      @(negedge clk);
      soft_rst = 1'b0; baud_we = 1'b0; baud_wdata = $urandom_range(0, 127);
   endtask

   task automatic load(logic [6:0] v, string req0);
      repeat ($urandom_range(0, 7)) @(negedge clk);
      pulse(1'b0, 1'b1, v);
      check(q0 == v && q1 == v, "R5", "loaded setting", int'(q0), int'(v));
      window(per(v, 1), per(v, 0), req0);
      check(q0 == v && q1 == v, "R9", "setting held", int'(q0), int'(v));
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(q0 == 7'h44 && q1 == 7'h44, "R1", "baud_q in reset", int'(q0), 'h44);
      check(!pt0 && !st0, "R1", "ticks in reset", int'(pt0), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(q0 == 7'h44, "R1", "baud_q after reset", int'(q0), 'h44);

      pulse(1'b1, 1'b0, 7'h00);
      check(q0 == 7'h44, "R6", "soft reset value", int'(q0), 'h44);
      window(288, 144, "R6");

      load(7'h00, "R7");
      load(7'h0B, "R2");
      load(7'h7F, "R2");

      for (int i = 0; i < 10; i++) begin
         logic [6:0] v;
         v = {4'($urandom_range(0, 15)), 3'($urandom_range(0, 4))};
         load(v, "R5");
      end

      // soft reset and write together: soft reset wins
      repeat (5) @(negedge clk);
      pulse(1'b1, 1'b1, 7'h0B);
      check(q0 == 7'h44, "R6", "soft reset priority over write", int'(q0), 'h44);
      window(288, 144, "R6");

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #1900000;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule